// File: doc/BRIEF.md
# Programmable Logic Cell with Split Lookup Table

This block is one programmable logic element of the kind that is repeated many times inside a configurable logic tile. Its function is held in a 16-bit truth table, organised as two 8-entry tables that both look at the three low logic inputs. In logic mode the fourth input chooses between the two table outputs, so the pair behaves as one 4-input function. In arithmetic mode the two table outputs become the operands of a full adder with a dedicated carry input. The adder's sum is the cell result, and its carry goes to the next cell.

A configuration word of 18 bits sets the table, the mode and the output timing. It is shifted in serially, one bit per clock, while the load strobe is high. The cell output comes either straight from the selected result or from a flip-flop that samples the result under a clock enable. That flip-flop has a synchronous clear and does not change while a configuration is being shifted in.

Top module: `lcell_top`

## Requirements
- R1: In logic mode (mode bit 0), the result equals table bit `{lin[3], lin[2], lin[1], lin[0]}`. Bits 7:0 therefore serve `lin[3]=0` and bits 15:8 serve `lin[3]=1`.
- R2: In arithmetic mode (mode bit 1), the result equals `T0 ^ T1 ^ carry_in`. Here T0 is table bit `{0, lin[2:0]}` and T1 is table bit `{1, lin[2:0]}`. `lin[3]` has no effect in this mode.
- R3: In arithmetic mode, `carry_out` is the majority of T0, T1 and `carry_in`. In logic mode, `carry_out` is 0.
- R4: While `cfg_load` is high, each rising clock edge shifts `cfg_din` into an 18-bit word, most significant bit first. After 18 such edges, bit 17 is the mode bit (1 = arithmetic), bit 16 is the output-timing bit (1 = registered), and bits 15:0 are the table. While `cfg_load` is low, the word is unchanged.
- R5: When the output-timing bit is 0, `cell_out` follows the result combinationally, within the same cycle as the input change.
- R6: When the output-timing bit is 1, `cell_out` shows the result captured at the last rising edge where `ce` was 1 and `cfg_load` was 0. While `ce` is 0, the captured value holds.
- R7: A rising edge with `srst` high clears both the flip-flop and the configuration word to 0. After this, `cell_out` and `carry_out` are 0.
- R8: While `cfg_load` is high, the flip-flop keeps its value even when `ce` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high clear of flip-flop and configuration |
| ce | input | 1 | Clock enable for the output flip-flop |
| cfg_load | input | 1 | Serial configuration shift strobe |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| lin | input | 4 | Logic inputs; lin[3] is the half-table select in logic mode |
| carry_in | input | 1 | Carry from the previous cell |
| cell_out | output | 1 | Cell output, combinational or registered |
| carry_out | output | 1 | Carry to the next cell |

## Verification
The bench programs seeded random tables in all four combinations of mode and output timing. It sweeps every input combination with both carry values and compares against a bench-side model.

Each kind of fault shows up in that sweep:
- A swapped half-table or a reversed bit index gives wrong results in logic mode.
- Letting `lin[3]` leak into the adder, or leaving carry-out live in logic mode, breaks the arithmetic checks.
- A wrong shift order scrambles the mode and timing bits, and every vector then misses.

Directed cases cover the flip-flop's timing:
- An enable that is ignored would pass new data through with `ce` low.
- A flip-flop that samples during loading would show the new table's value one cycle early.
- A reset that misses the configuration would leave a nonzero output after the clear.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_K    = 4;
    localparam int SUB_K    = LUT_K - 1;
    localparam int TBL_BITS = 1 << LUT_K;
    localparam int SUB_BITS = TBL_BITS / 2;
    localparam int CFG_BITS = TBL_BITS + 2;

    typedef enum logic {
        MODE_LOGIC = 1'b0,
        MODE_ARITH = 1'b1
    } cell_mode_t;

    // Packed MSB first: mode at the top, output timing next, table below.
    typedef struct packed {
        cell_mode_t          mode;
        logic                regd;
        logic [TBL_BITS-1:0] tbl;
    } cell_cfg_t;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      srst,
    input  logic      load,
    input  logic      din,
    output cell_cfg_t cfg
);

    logic [CFG_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (srst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= {shreg[CFG_BITS-2:0], din};
        end
    end

    assign cfg = cell_cfg_t'(shreg);

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (srst)
        load |=> shreg[0] == $past(din));

    // R4
    cfg_idle_chk: assert property (@(posedge clk) disable iff (srst)
        !load |=> $stable(shreg));

endmodule

// File: rtl/lcell_lut_pair.sv
module lcell_lut_pair
    import lcell_pkg::*;
(
    input  logic [TBL_BITS-1:0] tbl,
    input  logic [SUB_K-1:0]    sel,
    output logic [1:0]          half_out
);

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [SUB_BITS-1:0] sub_tbl;
        assign sub_tbl     = tbl[g*SUB_BITS +: SUB_BITS];
        assign half_out[g] = sub_tbl[sel];
    end

endmodule

// File: rtl/lcell_full_add.sv
module lcell_full_add
    import lcell_pkg::*;
(
    input  logic op_a,
    input  logic op_b,
    input  logic ci,
    output logic sum,
    output logic co
);

    assign sum = op_a ^ op_b ^ ci;
    assign co  = majority3(op_a, op_b, ci);

endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             ce,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] lin,
    input  logic             carry_in,
    output logic             cell_out,
    output logic             carry_out
);

    cell_cfg_t  cfg;
    logic [1:0] half_out;
    logic       logic_res;
    logic       add_sum;
    logic       add_co;
    logic       result;
    logic       q;

    lcell_cfg_chain u_cfg (
        .clk  (clk),
        .srst (srst),
        .load (cfg_load),
        .din  (cfg_din),
        .cfg  (cfg)
    );

    lcell_lut_pair u_luts (
        .tbl      (cfg.tbl),
        .sel      (lin[SUB_K-1:0]),
        .half_out (half_out)
    );

    lcell_full_add u_add (
        .op_a (half_out[0]),
        .op_b (half_out[1]),
        .ci   (carry_in),
        .sum  (add_sum),
        .co   (add_co)
    );

    // First mux: the top input picks a half-table in logic mode.
    assign logic_res = lin[LUT_K-1] ? half_out[1] : half_out[0];

    // Second mux: the mode bit picks the logic or the arithmetic result.
    always_comb begin
        unique case (cfg.mode)
            MODE_ARITH: begin
                result    = add_sum;
                carry_out = add_co;
            end
            default: begin
                result    = logic_res;
                carry_out = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            q <= 1'b0;
        end else if (ce && !cfg_load) begin
            q <= result;
        end
    end

    // Third mux: registered or direct output.
    assign cell_out = cfg.regd ? q : result;

    // R6
    ce_hold_chk: assert property (@(posedge clk) disable iff (srst)
        !ce |=> $stable(q));

    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (srst)
        cfg_load |=> $stable(q));

    // R7
    clear_chk: assert property (@(posedge clk)
        srst |=> (q == 1'b0) && (cell_out == 1'b0) && (carry_out == 1'b0));

    // R3
    carry_mode_chk: assert property (@(posedge clk) disable iff (srst)
        (cfg.mode == MODE_LOGIC) |-> (carry_out == 1'b0));

endmodule

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;

    localparam int CFGW = 18;

    logic       clk = 1'b0;
    logic       srst, ce, cfg_load, cfg_din, carry_in;
    logic [3:0] lin;
    logic       cell_out, carry_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    lcell_top i_lcell_top (
        .clk(clk), .srst(srst), .ce(ce), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .lin(lin), .carry_in(carry_in), .cell_out(cell_out), .carry_out(carry_out)
    );

    // Model: returns {carry, result} from the requirement text.
    function automatic logic [1:0] model(input logic [CFGW-1:0] w, input logic [3:0] x, input logic ci);
        logic t0, t1;
        t0 = w[{1'b0, x[2:0]}];
        t1 = w[{1'b1, x[2:0]}];
        if (w[17]) return {(t0 & t1) | (t0 & ci) | (t1 & ci), t0 ^ t1 ^ ci};
        return {1'b0, w[x]};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [CFGW-1:0] w);
        for (int k = CFGW - 1; k >= 0; k--) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_din  = w[k];
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Sweep all inputs and carries for one configuration word.
    task automatic sweep(input logic [CFGW-1:0] w);
        logic [1:0] e;
        for (int v = 0; v < 32; v++) begin
            lin      = v[3:0];
            carry_in = v[4];
            ce       = 1'b1;
            e = model(w, lin, carry_in);
            if (w[16]) begin
                @(negedge clk);
                check(w[17] ? "R2/R6 registered arith" : "R1/R6 registered logic", cell_out, e[0]);
                check("R3 carry registered", carry_out, e[1]);
            end else begin
                #1;
                check(w[17] ? "R2/R5 comb arith" : "R1/R5 comb logic", cell_out, e[0]);
                check("R3 carry comb", carry_out, e[1]);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        srst = 1'b1; ce = 1'b0; cfg_load = 1'b0; cfg_din = 1'b0; lin = 4'h0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset out", cell_out, 1'b0);
        check("R7 reset carry", carry_out, 1'b0);
        srst = 1'b0;

        // Directed: one-hot table entries check R1 indexing and R4 bit order.
        load_cfg({1'b0, 1'b0, 16'h0100});
        lin = 4'h8; #1; check("R1 index high half", cell_out, 1'b1);
        lin = 4'h0; #1; check("R1 index low half", cell_out, 1'b0);
        load_cfg({1'b0, 1'b0, 16'h0002});
        lin = 4'h1; #1; check("R4 table bit order", cell_out, 1'b1);
        // Arithmetic mode: lin[3] ignored (R2), carry from tables (R3).
        load_cfg({1'b1, 1'b0, 16'hFF00});
        carry_in = 1'b1;
        lin = 4'h3; #1; check("R2 arith sum", cell_out, 1'b0);
        check("R3 arith carry", carry_out, 1'b1);
        lin = 4'hB; #1; check("R2 lin3 ignored", cell_out, 1'b0);
        check("R3 lin3 ignored carry", carry_out, 1'b1);
        carry_in = 1'b0;

        // Random sweeps over all mode/output combinations.
        for (int c = 0; c < 8; c++) begin
            logic [15:0] t;
            t = 16'($urandom());
            for (int m = 0; m < 4; m++) begin
                logic [CFGW-1:0] w;
                w = {m[1], m[0], t};
                load_cfg(w);
                sweep(w);
            end
        end

        // R6: clock enable holds the registered value.
        load_cfg({1'b0, 1'b1, 16'h00FF});
        ce = 1'b1; lin = 4'h0;
        @(negedge clk); check("R6 capture", cell_out, 1'b1);
        ce = 1'b0; lin = 4'h8;
        @(negedge clk); check("R6 ce low hold", cell_out, 1'b1);
        ce = 1'b1;
        @(negedge clk); check("R6 ce high capture", cell_out, 1'b0);

        // R8: flip-flop holds while a new configuration is shifted in.
        load_cfg({1'b0, 1'b1, 16'hFFFF});
        @(negedge clk); check("R8 setup", cell_out, 1'b1);
        load_cfg({1'b0, 1'b1, 16'h0000});
        check("R8 hold during load", cell_out, 1'b1);
        @(negedge clk); check("R8 capture after load", cell_out, 1'b0);

        // R7: clear after a 1 has been captured, with ce low.
        load_cfg({1'b1, 1'b1, 16'hFFFF});
        lin = 4'h0; carry_in = 1'b1;
        @(negedge clk); check("R7 setup", cell_out, 1'b1);
        ce = 1'b0; srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        #1;
        check("R7 clear out", cell_out, 1'b0);
        check("R7 clear carry", carry_out, 1'b0);

        finish_run();
    end

endmodule